// File: doc/BRIEF.md
# Serial PHY Status Word Receiver

This block sits on the link side of a serial bus PHY. It watches a 2-bit control code and a 2-bit data lane on every clock. When the control code shows a status transfer, the block gathers two status bits per cycle until it has a 16-bit word. The first four bits are status flags, and the block reports them as soon as they have arrived. The remaining twelve bits hold a register address and that register's contents. The block reports them only when the whole word has been received.

The PHY may cut a transfer short at any cycle by switching the control code, which it does when a packet begins to arrive. The block then drops the partial address and data and raises an abort pulse. Transfers are always separated by at least one idle code. The block starts a fresh word only after seeing that idle code. When a completed word reports the physical-ID register, the block keeps the node ID it carries on a separate output. This covers the report the PHY sends on its own after self-identification.

The status stream comes from the PHY and cannot be stalled, so the outputs carry no back-pressure. Each valid indication is a single-cycle pulse. The fields that go with a pulse stay unchanged until the next pulse of the same kind. A consumer that is not ready in that cycle misses the report.

Top module: `phy_status_rx`

## Requirements
- R1: A synchronous active-high reset drives all of these outputs to 0: flags, flags_valid, reg_addr, reg_data, reg_valid, aborted and node_id. After reset the block waits in idle.
- R2: A word starts when ctl = 01 in idle. In the k-th status cycle (k = 0..7), d[1] carries S[2k] and d[0] carries S[2k+1].
- R3: One cycle after the second consecutive status cycle, flags_valid pulses for one cycle. flags = {S0,S1,S2,S3}, with S0 in flags[3].
- R4: One cycle after the eighth consecutive status cycle, reg_valid pulses for one cycle. reg_addr = {S4..S7} with S4 as its MSB. reg_data = {S8..S15} with S8 as its MSB.
- R5: If ctl leaves 01 after one to seven status cycles, aborted pulses for one cycle in the next cycle. In that case reg_valid does not pulse, and reg_addr and reg_data keep their previous values.
- R6: After a complete word, further cycles with ctl = 01 are ignored until ctl = 00 has been seen.
- R7: After an abort with ctl = 10 or 11, or after ctl = 10 or 11 in idle, cycles with ctl = 01 are ignored until ctl = 00 has been seen.
- R8: When a complete word has reg_addr = 0, node_id takes {S8..S13} (reg_data[7:2]) in the same cycle as reg_valid. Otherwise node_id holds its value.
- R9: flags changes only in a cycle in which flags_valid or reg_valid is high. An abort after a single status cycle leaves flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl | input | 2 | Control code from the PHY (00 idle, 01 status) |
| d | input | 2 | Status data lane |
| flags | output | 4 | Status flags S0..S3 |
| flags_valid | output | 1 | Single-cycle pulse: flags have been captured |
| reg_addr | output | 4 | Register address of the last complete word |
| reg_data | output | 8 | Register contents of the last complete word |
| reg_valid | output | 1 | Single-cycle pulse: a full word has been received |
| aborted | output | 1 | Single-cycle pulse: a partial word was dropped |
| node_id | output | 6 | Node ID from the last physical-ID report |

## Verification
Complete words with random contents check the bit order and the split into flags, address and data. Words with address 0 are mixed with words at other addresses, which shows whether the node ID is latched selectively. Transfers cut after one, two or seven cycles, with each possible terminating code, separate flag reporting, discarding of the partial word and the abort pulse. Extra status cycles after a full word, status codes following a packet code with no idle between them, and a reset in the middle of a word show whether a fresh word can start only from idle.

// File: rtl/phy_status_pkg.sv
package phy_status_pkg;
  localparam logic [1:0] CTL_IDLE   = 2'b00;
  localparam logic [1:0] CTL_STATUS = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } rx_state_t;
endpackage

// File: rtl/phy_status_shift.sv
module phy_status_shift #(
  parameter int WORD_BITS = 16,
  parameter int LANE_BITS = 2,
  parameter int CNT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 shift,
  input  logic [LANE_BITS-1:0] d,
  output logic [WORD_BITS-1:0] word_nxt,
  output logic [CNT_W-1:0]     cnt
);
  logic [WORD_BITS-1:0] sr;

  // the first beat of a word discards whatever the register held before
  always_comb begin
    if (start) word_nxt = {{(WORD_BITS-LANE_BITS){1'b0}}, d};
    else       word_nxt = {sr[WORD_BITS-LANE_BITS-1:0], d};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      cnt <= '0;
    end else if (start) begin
      sr  <= word_nxt;
      cnt <= CNT_W'(1);
    end else if (shift) begin
      sr  <= word_nxt;
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/phy_status_ctrl.sv
module phy_status_ctrl
  import phy_status_pkg::*;
#(
  parameter int BEATS      = 8,
  parameter int FLAG_BEATS = 2,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       ctl,
  input  logic [CNT_W-1:0] cnt,
  output logic             start,
  output logic             shift,
  output logic             done,
  output logic             abort,
  output logic             flag_hit
);
  rx_state_t st, st_nxt;
  logic is_status, is_idle;

  assign is_status = (ctl == CTL_STATUS);
  assign is_idle   = (ctl == CTL_IDLE);

  assign start    = (st == ST_IDLE) && is_status;
  assign shift    = (st == ST_SHIFT) && is_status;
  assign abort    = (st == ST_SHIFT) && !is_status;
  assign done     = shift && (cnt == CNT_W'(BEATS-1));
  assign flag_hit = shift && (cnt == CNT_W'(FLAG_BEATS-1));

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_IDLE: begin
        if (is_status)     st_nxt = ST_SHIFT;
        else if (!is_idle) st_nxt = ST_HOLD;
      end
      ST_SHIFT: begin
        if (done)          st_nxt = ST_HOLD;
        else if (is_idle)  st_nxt = ST_IDLE;
        else if (abort)    st_nxt = ST_HOLD;
      end
      ST_HOLD: begin
        if (is_idle)       st_nxt = ST_IDLE;
      end
      default:             st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nxt;
  end
endmodule

// File: rtl/phy_status_fields.sv
module phy_status_fields #(
  parameter int WORD_BITS  = 16,
  parameter int FLAG_BITS  = 4,
  parameter int ADDR_BITS  = 4,
  parameter int DATA_BITS  = 8,
  parameter int ID_BITS    = 6,
  parameter int PHYID_ADDR = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [WORD_BITS-1:0] word,
  input  logic                 flag_hit,
  input  logic                 done,
  input  logic                 abort,
  output logic [FLAG_BITS-1:0] flags,
  output logic                 flags_valid,
  output logic [ADDR_BITS-1:0] reg_addr,
  output logic [DATA_BITS-1:0] reg_data,
  output logic                 reg_valid,
  output logic                 aborted,
  output logic [ID_BITS-1:0]   node_id
);
  logic [ADDR_BITS-1:0] w_addr;
  logic [DATA_BITS-1:0] w_data;
  logic [FLAG_BITS-1:0] w_flags_full;
  logic [FLAG_BITS-1:0] w_flags_early;

  // the flags lead the word and the data field trails it
  assign w_flags_full  = word[WORD_BITS-1 -: FLAG_BITS];
  assign w_addr        = word[WORD_BITS-FLAG_BITS-1 -: ADDR_BITS];
  assign w_data        = word[DATA_BITS-1:0];
  assign w_flags_early = word[FLAG_BITS-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      flags       <= '0;
      flags_valid <= 1'b0;
      reg_addr    <= '0;
      reg_data    <= '0;
      reg_valid   <= 1'b0;
      aborted     <= 1'b0;
      node_id     <= '0;
    end else begin
      flags_valid <= flag_hit;
      reg_valid   <= done;
      aborted     <= abort;
      if (flag_hit) flags <= w_flags_early;
      if (done) begin
        flags    <= w_flags_full;
        reg_addr <= w_addr;
        reg_data <= w_data;
        if (w_addr == ADDR_BITS'(PHYID_ADDR))
          node_id <= w_data[DATA_BITS-1 -: ID_BITS];
      end
    end
  end
endmodule

// File: rtl/phy_status_rx.sv
module phy_status_rx #(
  parameter int WORD_BITS  = 16,
  parameter int LANE_BITS  = 2,
  parameter int FLAG_BITS  = 4,
  parameter int ADDR_BITS  = 4,
  parameter int ID_BITS    = 6,
  parameter int PHYID_ADDR = 0
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic [1:0]                                ctl,
  input  logic [LANE_BITS-1:0]                      d,
  output logic [FLAG_BITS-1:0]                      flags,
  output logic                                      flags_valid,
  output logic [ADDR_BITS-1:0]                      reg_addr,
  output logic [WORD_BITS-FLAG_BITS-ADDR_BITS-1:0]  reg_data,
  output logic                                      reg_valid,
  output logic                                      aborted,
  output logic [ID_BITS-1:0]                        node_id
);
  localparam int DATA_BITS  = WORD_BITS - FLAG_BITS - ADDR_BITS;
  localparam int BEATS      = WORD_BITS / LANE_BITS;
  localparam int FLAG_BEATS = FLAG_BITS / LANE_BITS;
  localparam int CNT_W      = $clog2(BEATS + 1);

  logic                 start, shift, done, abort, flag_hit;
  logic [CNT_W-1:0]     cnt;
  logic [WORD_BITS-1:0] word_nxt;

  phy_status_ctrl #(
    .BEATS(BEATS), .FLAG_BEATS(FLAG_BEATS), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .ctl(ctl), .cnt(cnt),
    .start(start), .shift(shift), .done(done),
    .abort(abort), .flag_hit(flag_hit)
  );

  phy_status_shift #(
    .WORD_BITS(WORD_BITS), .LANE_BITS(LANE_BITS), .CNT_W(CNT_W)
  ) u_shift (
    .clk(clk), .rst(rst), .start(start), .shift(shift), .d(d),
    .word_nxt(word_nxt), .cnt(cnt)
  );

  phy_status_fields #(
    .WORD_BITS(WORD_BITS), .FLAG_BITS(FLAG_BITS), .ADDR_BITS(ADDR_BITS),
    .DATA_BITS(DATA_BITS), .ID_BITS(ID_BITS), .PHYID_ADDR(PHYID_ADDR)
  ) u_fields (
    .clk(clk), .rst(rst), .word(word_nxt), .flag_hit(flag_hit),
    .done(done), .abort(abort),
    .flags(flags), .flags_valid(flags_valid),
    .reg_addr(reg_addr), .reg_data(reg_data), .reg_valid(reg_valid),
    .aborted(aborted), .node_id(node_id)
  );
endmodule

// File: rtl/phy_status_rx_chk.sv
module phy_status_rx_chk #(
  parameter int FLAG_BITS  = 4,
  parameter int ADDR_BITS  = 4,
  parameter int ID_BITS    = 6,
  parameter int PHYID_ADDR = 0
) (
  input logic                 clk,
  input logic                 rst,
  input logic [FLAG_BITS-1:0] flags,
  input logic                 flags_valid,
  input logic [ADDR_BITS-1:0] reg_addr,
  input logic                 reg_valid,
  input logic                 aborted,
  input logic [ID_BITS-1:0]   node_id
);
  // R3
  flags_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    flags_valid |=> !flags_valid);
  // R4
  reg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reg_valid |=> !reg_valid);
  // R4
  rv_fv_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_valid && flags_valid));
  // R5
  abort_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(aborted && reg_valid));
  // R5
  abort_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    aborted |=> !aborted);
  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!reg_valid && !$past(rst)) |-> $stable(reg_addr));
  // R8
  node_id_src_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(node_id) && !$past(rst)) |->
      (reg_valid && reg_addr == ADDR_BITS'(PHYID_ADDR)));
  // R9
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!flags_valid && !reg_valid && !$past(rst)) |-> $stable(flags));
endmodule

bind phy_status_rx phy_status_rx_chk #(
  .FLAG_BITS(FLAG_BITS), .ADDR_BITS(ADDR_BITS),
  .ID_BITS(ID_BITS), .PHYID_ADDR(PHYID_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .flags(flags), .flags_valid(flags_valid),
  .reg_addr(reg_addr), .reg_valid(reg_valid), .aborted(aborted),
  .node_id(node_id)
);

// File: tb/phy_status_rx_tb.sv
module phy_status_rx_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ctl = 2'b00;
  logic [1:0] d   = 2'b00;
  logic [3:0] flags;
  logic       flags_valid;
  logic [3:0] reg_addr;
  logic [7:0] reg_data;
  logic       reg_valid;
  logic       aborted;
  logic [5:0] node_id;

  int n_checks = 0;
  int n_errs   = 0;
  string ctx = "R2";

  // bench reference state
  int          m_mode;   // 0 idle, 1 gathering, 2 waiting for idle
  int          m_beats;
  logic [15:0] m_acc;
  logic        e_fv, e_rv, e_ab;
  logic [3:0]  e_flags, e_addr;
  logic [7:0]  e_data;
  logic [5:0]  e_nid;

  always #5 clk = ~clk;

  phy_status_rx u_dut (
    .clk(clk), .rst(rst), .ctl(ctl), .d(d),
    .flags(flags), .flags_valid(flags_valid), .reg_addr(reg_addr),
    .reg_data(reg_data), .reg_valid(reg_valid), .aborted(aborted),
    .node_id(node_id)
  );

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, ctx, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mode = 0; m_beats = 0; m_acc = '0;
    e_fv = 0; e_rv = 0; e_ab = 0;
    e_flags = '0; e_addr = '0; e_data = '0; e_nid = '0;
  endtask

  task automatic model_step(logic [1:0] c, logic [1:0] dd);
    e_fv = 0; e_rv = 0; e_ab = 0;
    case (m_mode)
      0: begin
        if (c == 2'b01) begin m_acc = {14'b0, dd}; m_beats = 1; m_mode = 1; end
        else if (c != 2'b00) m_mode = 2;
      end
      1: begin
        if (c == 2'b01) begin
          m_acc = {m_acc[13:0], dd};
          m_beats++;
          if (m_beats == 2) begin e_fv = 1; e_flags = m_acc[3:0]; end
          if (m_beats == 8) begin
            e_rv = 1; e_flags = m_acc[15:12];
            e_addr = m_acc[11:8]; e_data = m_acc[7:0];
            if (m_acc[11:8] == 4'd0) e_nid = m_acc[7:2];
            m_mode = 2;
          end
        end else begin
          e_ab = 1;
          m_mode = (c == 2'b00) ? 0 : 2;
        end
      end
      default: if (c == 2'b00) m_mode = 0;
    endcase
  endtask

  task automatic compare_all();
    check("R3", flags_valid, e_fv);
    check("R4", reg_valid, e_rv);
    check("R5", aborted, e_ab);
    check("R9", flags, e_flags);
    check("R4", reg_addr, e_addr);
    check("R4", reg_data, e_data);
    check("R8", node_id, e_nid);
  endtask

  // drive one cycle at the falling edge, check after the next falling edge
  task automatic tick(logic [1:0] c, logic [1:0] dd);
    ctl = c; d = dd;
    model_step(c, dd);
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    rst = 1'b1; ctl = 2'b00; d = 2'b00;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    ctx = "R1";
    compare_all();
  endtask

  task automatic send(logic [15:0] w, int nb, logic [1:0] endc);
    for (int k = 0; k < nb; k++) begin
      logic [1:0] dd;
      if (k < 8) dd = 2'((w >> (14 - 2*k)) & 16'h3);
      else       dd = 2'($urandom_range(0, 3));
      tick(2'b01, dd);
    end
    tick(endc, 2'b00);
  endtask

  initial begin
    #2000000;
    n_errs++;
    $display("FAIL watchdog expired [%s]", ctx);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h1394));
    @(negedge clk);
    do_reset();

    ctx = "R8 physical id report";
    send({4'hA, 4'h0, 8'hB4}, 8, 2'b00);
    check("R8", node_id, 6'h2D);
    ctx = "R8 other address";
    send({4'h5, 4'h5, 8'h3C}, 8, 2'b00);
    check("R8", node_id, 6'h2D);
    check("R4", reg_addr, 4'h5);

    ctx = "R5 abort after one beat";
    send({4'hF, 4'h1, 8'hFF}, 1, 2'b10);
    check("R9", flags, 4'h5);
    ctx = "R7 status after abort without idle";
    send({4'h3, 4'h2, 8'h11}, 8, 2'b00);
    check("R7", reg_addr, 4'h5);
    ctx = "R2 fresh word after idle";
    send({4'hC, 4'h9, 8'h5A}, 8, 2'b00);
    check("R2", reg_data, 8'h5A);

    ctx = "R5 abort after flags";
    send({4'h6, 4'h7, 8'h77}, 2, 2'b00);
    check("R3", flags, 4'h6);
    ctx = "R5 abort at last beat";
    send({4'h1, 4'h0, 8'hFC}, 7, 2'b11);
    tick(2'b00, 2'b00);
    check("R5", node_id, 6'h2D);

    ctx = "R6 extra status after full word";
    send({4'h2, 4'h4, 8'h81}, 10, 2'b00);
    check("R6", reg_addr, 4'h4);

    ctx = "R7 packet code from idle";
    tick(2'b10, 2'b00);
    send({4'h9, 4'h0, 8'h00}, 8, 2'b00);
    check("R7", node_id, 6'h2D);

    ctx = "R1 reset mid word";
    send({4'h8, 4'h3, 8'h33}, 3, 2'b01);
    do_reset();

    ctx = "R2 random traffic";
    for (int i = 0; i < 400; i++) begin
      logic [15:0] w;
      int nb;
      logic [1:0] endc;
      w = 16'($urandom);
      if ($urandom_range(0, 3) == 0) w[11:8] = 4'h0;
      nb = $urandom_range(1, 9);
      case ($urandom_range(0, 2))
        0: endc = 2'b00;
        1: endc = 2'b10;
        default: endc = 2'b11;
      endcase
      send(w, nb, endc);
      for (int g = 0; g < int'($urandom_range(0, 2)); g++)
        tick(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
      tick(2'b00, 2'b00);
    end

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule